// File: doc/BRIEF.md
# Host-to-Local Address Remap Window

This block places one programmable window between the firmware address space seen by a host bus and the address space of the local system bus. Each host request presents a 32-bit address, a valid strobe and a one-bit cycle kind. The block decides whether the request falls inside the window and whether that kind of cycle is currently allowed. Exactly one cycle later it reports either a hit, with the translated local address, or a miss.

The window works on 64 KiB pages. Only address bits 31:16 take part in matching and translation, and bits 15:0 always pass through unchanged. The window register holds two page numbers: the local base and the host-side window address. The mask register holds two per-bit fields. The first field lists the request bits to keep. The second lists the bits to replace with the local base. A control register enables each cycle kind separately. A mode/status register holds a translation-mode bit for firmware-hub cycles and two sticky event flags, and each flag is cleared by writing 1 to it.

Software programs all four registers through a single write/read port. A request that arrives on the same clock edge as a register write still uses the register values from before that write.

Top module: `hlwin_remap`

## Requirements
- R1: After reset, every register reads 0, both cycle kinds are disabled and every request misses.
- R2: A request sampled with `req_valid_i` high produces `rsp_valid_o` high on the next cycle, with exactly one of `rsp_hit_o` or `rsp_miss_o` set. Without a request, `rsp_valid_o`, `rsp_hit_o` and `rsp_miss_o` are all low on the next cycle.
- R3: A request is inside the window when request bits 31:16 equal window register bits 15:0 at every position where mask bits 15:0 are 0.
- R4: On a hit that is translated, result bits 31:16 are (request bits 31:16 AND mask bits 15:0) OR (window bits 31:16 AND mask bits 31:16). On any non-hit, `rsp_addr_o` is 0.
- R5: On every hit, `rsp_addr_o` bits 15:0 equal request bits 15:0.
- R6: `req_kind_i` = 0 marks a host-to-local memory cycle and is enabled by control register (select 0) bit 8. `req_kind_i` = 1 marks a firmware-hub cycle and is enabled by bit 10. A request of a disabled kind never hits, even when it is inside the window.
- R7: Mode/status register (select 1) bit 17 selects how firmware-hub hits are translated. When it is 0, such hits return the request address unchanged. When it is 1, they are translated as in R4. Memory-cycle hits are always translated.
- R8: In the mode/status register, bit 0 is set by every miss and bit 1 is set by a request that is inside the window but of a disabled kind. Writing 1 clears a flag and writing 0 leaves it unchanged. An event in the same cycle as a clearing write leaves the flag set. Reads show the current flag values.
- R9: A register write takes effect for requests sampled on later edges. A request sampled on the same edge as the write is evaluated with the old register values.
- R10: Register select 0 stores only bits 8 and 10. Select 1 stores bit 17 and shows the flags in bits 1:0. Selects 2 (window) and 3 (mask) store all 32 bits. Bits that are not stored read as 0.
- R11: Program a power-of-two size S of at least 64 KiB with mask bits 31:16 = upper half of ~(S-1), mask bits 15:0 = (S>>16)-1, and a host address and local base that are multiples of S. The window then maps host addresses [host, host+S) onto [base, base+S), and host+S misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host request strobe |
| req_kind_i | input | 1 | Cycle kind: 0 memory, 1 firmware-hub |
| req_addr_i | input | 32 | Host-side request address |
| rsp_valid_o | output | 1 | Result of the previous cycle's request is present |
| rsp_hit_o | output | 1 | Request was inside the window and its kind was enabled |
| rsp_miss_o | output | 1 | Request was rejected |
| rsp_addr_o | output | 32 | Translated local address, 0 when not a hit |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select for write and read: 0 control, 1 mode/status, 2 window, 3 mask |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register, current value |

## Verification
The bench works the page boundaries of a 1 MiB window. It checks the last byte inside the window, the first byte past it and the byte just below it. A design with a flipped mask polarity or an off-by-one compare would hit at the wrong edge or translate to the wrong base. It also checks that a request of a disabled kind is refused even though its address matches, and that firmware-hub hits switch between identity and translation with the mode bit. A design that gated on the wrong enable bit or ignored the mode would return the wrong address. The sticky flags are tested with a write of 0, a write of 1, and a write of 1 that coincides with a miss. A design that let the write win would lose the new event. Finally, a request sampled on the same edge as a window rewrite must still use the old base. A design that evaluated requests on the incoming register value would show the new base one request too early.

// File: rtl/hlwin_pkg.sv
package hlwin_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_WIN  = 2'd2,
        REG_MASK = 2'd3
    } reg_sel_e;

    typedef enum logic {
        KIND_MEM = 1'b0,
        KIND_FWH = 1'b1
    } req_kind_e;

    // control register enable positions
    localparam int unsigned EN_MEM_BIT   = 8;
    localparam int unsigned EN_FWH_BIT   = 10;
    // mode/status register layout
    localparam int unsigned MODE_FWH_BIT = 17;
    localparam int unsigned NSTAT        = 2;
    localparam int unsigned ST_MISS      = 0;
    localparam int unsigned ST_BLOCK     = 1;

endpackage

// File: rtl/hlwin_regs.sv
module hlwin_regs
    import hlwin_pkg::*;
#(
    parameter int unsigned REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [NSTAT-1:0] st_set,
    output logic [REG_W-1:0] rd_data,
    output logic             en_mem,
    output logic             en_fwh,
    output logic             mode_fwh,
    output logic [REG_W-1:0] win,
    output logic [REG_W-1:0] mask
);

    typedef struct packed {
        logic             en_mem;
        logic             en_fwh;
        logic             mode_fwh;
        logic [NSTAT-1:0] st;
        logic [REG_W-1:0] win;
        logic [REG_W-1:0] mask;
    } regs_t;

    regs_t r_d, r_q;

    logic wr_ctrl, wr_stat, wr_win, wr_mask;
    logic [NSTAT-1:0] st_clr;

    assign wr_ctrl = wr_en && (sel == REG_CTRL);
    assign wr_stat = wr_en && (sel == REG_STAT);
    assign wr_win  = wr_en && (sel == REG_WIN);
    assign wr_mask = wr_en && (sel == REG_MASK);

    for (genvar i = 0; i < NSTAT; i++) begin : g_clr
        assign st_clr[i] = wr_stat && wr_data[i];
    end

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            r_d.en_mem = wr_data[EN_MEM_BIT];
            r_d.en_fwh = wr_data[EN_FWH_BIT];
        end
        if (wr_stat) begin
            r_d.mode_fwh = wr_data[MODE_FWH_BIT];
        end
        // an event in the same cycle outranks a clearing write
        r_d.st = (r_q.st & ~st_clr) | st_set;
        if (wr_win) begin
            r_d.win = wr_data;
        end
        if (wr_mask) begin
            r_d.mask = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (sel)
            REG_CTRL: begin
                rd_data[EN_MEM_BIT] = r_q.en_mem;
                rd_data[EN_FWH_BIT] = r_q.en_fwh;
            end
            REG_STAT: begin
                rd_data[MODE_FWH_BIT] = r_q.mode_fwh;
                rd_data[NSTAT-1:0]    = r_q.st;
            end
            REG_WIN:  rd_data = r_q.win;
            REG_MASK: rd_data = r_q.mask;
            default:  rd_data = '0;
        endcase
    end

    assign en_mem   = r_q.en_mem;
    assign en_fwh   = r_q.en_fwh;
    assign mode_fwh = r_q.mode_fwh;
    assign win      = r_q.win;
    assign mask     = r_q.mask;

    // R8
    st_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wr_data[ST_MISS] && !st_set[ST_MISS]) |=> !r_q.st[ST_MISS]);

    // R8
    st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st[ST_MISS] && !(wr_stat && wr_data[ST_MISS])) |=> r_q.st[ST_MISS]);

    // R8
    st_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_set[ST_BLOCK] |=> r_q.st[ST_BLOCK]);

    // R10
    win_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_win |=> (r_q.win == $past(wr_data)));

endmodule

// File: rtl/hlwin_match.sv
module hlwin_match
    import hlwin_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned PAGE_W = 16,
    localparam int unsigned HI_W  = ADDR_W - PAGE_W,
    localparam int unsigned REG_W = 2 * HI_W
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  req_kind_e         req_kind,
    input  logic [REG_W-1:0]  win,
    input  logic [REG_W-1:0]  mask,
    input  logic              en_mem,
    input  logic              en_fwh,
    input  logic              mode_fwh,
    output logic              hit,
    output logic              blocked,
    output logic [ADDR_W-1:0] out_addr
);

    logic [HI_W-1:0] req_hi, base_hi, host_hi, keep, repl;
    logic [HI_W-1:0] diff, merged;
    logic            in_win, kind_en, identity;

    assign req_hi  = req_addr[ADDR_W-1:PAGE_W];
    assign base_hi = win[REG_W-1:HI_W];
    assign host_hi = win[HI_W-1:0];
    assign repl    = mask[REG_W-1:HI_W];
    assign keep    = mask[HI_W-1:0];

    for (genvar b = 0; b < HI_W; b++) begin : g_bit
        assign diff[b]   = (req_hi[b] ^ host_hi[b]) & ~keep[b];
        assign merged[b] = (req_hi[b] & keep[b]) | (base_hi[b] & repl[b]);
    end

    assign in_win   = ~|diff;
    assign kind_en  = (req_kind == KIND_FWH) ? en_fwh : en_mem;
    assign hit      = in_win && kind_en;
    assign blocked  = in_win && !kind_en;
    assign identity = (req_kind == KIND_FWH) && !mode_fwh;

    always_comb begin
        if (identity) begin
            out_addr = req_addr;
        end else begin
            out_addr = {merged, req_addr[PAGE_W-1:0]};
        end
    end

endmodule

// File: rtl/hlwin_remap.sv
module hlwin_remap
    import hlwin_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned PAGE_W = 16,
    localparam int unsigned HI_W  = ADDR_W - PAGE_W,
    localparam int unsigned REG_W = 2 * HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_kind_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic              rsp_miss_o,
    output logic [ADDR_W-1:0] rsp_addr_o,
    input  logic              reg_we_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o
);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              miss;
        logic [ADDR_W-1:0] addr;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [REG_W-1:0]  win, mask;
    logic              en_mem, en_fwh, mode_fwh;
    logic              m_hit, m_blocked;
    logic [ADDR_W-1:0] m_addr;
    logic [NSTAT-1:0]  st_set;

    hlwin_regs #(.REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we_i),
        .sel      (reg_sel_e'(reg_sel_i)),
        .wr_data  (reg_wdata_i),
        .st_set   (st_set),
        .rd_data  (reg_rdata_o),
        .en_mem   (en_mem),
        .en_fwh   (en_fwh),
        .mode_fwh (mode_fwh),
        .win      (win),
        .mask     (mask)
    );

    hlwin_match #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_match (
        .req_addr (req_addr_i),
        .req_kind (req_kind_e'(req_kind_i)),
        .win      (win),
        .mask     (mask),
        .en_mem   (en_mem),
        .en_fwh   (en_fwh),
        .mode_fwh (mode_fwh),
        .hit      (m_hit),
        .blocked  (m_blocked),
        .out_addr (m_addr)
    );

    always_comb begin
        rsp_d.valid = req_valid_i;
        rsp_d.hit   = req_valid_i && m_hit;
        rsp_d.miss  = req_valid_i && !m_hit;
        rsp_d.addr  = (req_valid_i && m_hit) ? m_addr : '0;
        st_set           = '0;
        st_set[ST_MISS]  = req_valid_i && !m_hit;
        st_set[ST_BLOCK] = req_valid_i && m_blocked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid_o = rsp_q.valid;
    assign rsp_hit_o   = rsp_q.hit;
    assign rsp_miss_o  = rsp_q.miss;
    assign rsp_addr_o  = rsp_q.addr;

    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!rsp_valid_o && !rsp_hit_o && !rsp_miss_o));

    // R2
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (rsp_hit_o != rsp_miss_o));

    // R5
    low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> (!rsp_hit_o || (rsp_addr_o[PAGE_W-1:0] == $past(req_addr_i[PAGE_W-1:0]))));

    // R6
    kind_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && ((req_kind_i && !en_fwh) || (!req_kind_i && !en_mem))) |=> !rsp_hit_o);

    // R7
    fwh_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_kind_i && !mode_fwh) |=> (!rsp_hit_o || (rsp_addr_o == $past(req_addr_i))));

endmodule

// File: tb/hlwin_remap_bench.sv
`timescale 1ns/1ps
module hlwin_remap_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_kind;
    logic [31:0] req_addr;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [31:0] rsp_addr;
    logic        reg_we;
    logic [1:0]  reg_sel;
    logic [31:0] reg_wdata, reg_rdata;

    always #10 clk = ~clk;

    hlwin_remap u_hlwin_remap (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_kind_i  (req_kind),
        .req_addr_i  (req_addr),
        .rsp_valid_o (rsp_valid),
        .rsp_hit_o   (rsp_hit),
        .rsp_miss_o  (rsp_miss),
        .rsp_addr_o  (rsp_addr),
        .reg_we_i    (reg_we),
        .reg_sel_i   (reg_sel),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata)
    );

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 0;
    string cur_req = "R1";

    // reference state
    logic [31:0] m_ctrl, m_stat, m_win, m_msk;
    logic        e_valid, e_hit, e_miss;
    logic [31:0] e_addr;

    function automatic logic [31:0] model_read(input logic [1:0] s);
        case (s)
            2'd0: return m_ctrl;
            2'd1: return m_stat;
            2'd2: return m_win;
            default: return m_msk;
        endcase
    endfunction

    task automatic model_update(input bit v, input bit k, input logic [31:0] a,
                                input bit we, input logic [1:0] s, input logic [31:0] wd);
        logic [15:0] hi, keep, rep, host, base;
        logic [1:0]  ev;
        bit inw, en, h;
        hi   = a[31:16];
        keep = m_msk[15:0];
        rep  = m_msk[31:16];
        host = m_win[15:0];
        base = m_win[31:16];
        inw  = (((hi ^ host) & ~keep) == 16'h0);
        en   = k ? m_ctrl[10] : m_ctrl[8];
        h    = v && inw && en;
        e_valid = v;
        e_hit   = h;
        e_miss  = v && !h;
        if (!h)                     e_addr = 32'h0;
        else if (k && !m_stat[17])  e_addr = a;
        else                        e_addr = {(hi & keep) | (base & rep), a[15:0]};
        ev = {v && inw && !en, v && !h};
        if (we && s == 2'd1)
            m_stat = {14'h0, wd[17], 15'h0, (m_stat[1:0] & ~wd[1:0]) | ev};
        else
            m_stat[1:0] = m_stat[1:0] | ev;
        if (we && s == 2'd0) m_ctrl = wd & 32'h0000_0500;
        if (we && s == 2'd2) m_win  = wd;
        if (we && s == 2'd3) m_msk  = wd;
    endtask

    task automatic compare();
        logic [66:0] got, exp;
        got = {rsp_valid, rsp_hit, rsp_miss, rsp_addr, reg_rdata};
        exp = {e_valid, e_hit, e_miss, e_addr, model_read(reg_sel)};
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s cycle: got v=%0b h=%0b m=%0b addr=%h rd=%h exp v=%0b h=%0b m=%0b addr=%h rd=%h",
                     cur_req, rsp_valid, rsp_hit, rsp_miss, rsp_addr, reg_rdata,
                     e_valid, e_hit, e_miss, e_addr, model_read(reg_sel));
        end
    endtask

    // drive at negedge, model at posedge, compare at the following negedge
    task automatic step(input bit v, input bit k, input logic [31:0] a,
                        input bit we, input logic [1:0] s, input logic [31:0] wd);
        req_valid = v; req_kind = k; req_addr = a;
        reg_we = we; reg_sel = s; reg_wdata = wd;
        @(posedge clk);
        model_update(v, k, a, we, s, wd);
        @(negedge clk);
        compare();
    endtask

    task automatic expect_rsp(input string tag, input bit hit, input logic [31:0] addr);
        n_chk++;
        if (rsp_valid !== 1'b1 || rsp_hit !== hit || rsp_miss !== !hit || rsp_addr !== addr) begin
            n_err++;
            $display("FAIL %s: got v=%0b h=%0b m=%0b addr=%h exp v=1 h=%0b m=%0b addr=%h",
                     tag, rsp_valid, rsp_hit, rsp_miss, rsp_addr, hit, !hit, addr);
        end
    endtask

    task automatic expect_rd(input string tag, input logic [31:0] val);
        n_chk++;
        if (reg_rdata !== val) begin
            n_err++;
            $display("FAIL %s: read sel=%0d got %h exp %h", tag, reg_sel, reg_rdata, val);
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL R2 watchdog: got no completion exp completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 0; req_kind = 0; req_addr = '0;
        reg_we = 0; reg_sel = 0; reg_wdata = '0;
        m_ctrl = '0; m_stat = '0; m_win = '0; m_msk = '0;
        e_valid = 0; e_hit = 0; e_miss = 0; e_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cur_req = "R1";
        for (int s = 0; s < 4; s++) begin
            step(0, 0, 32'h0, 0, 2'(s), 32'h0);
            expect_rd("R1 reset read", 32'h0);
        end
        step(1, 0, 32'h0000_1234, 0, 2'd0, 32'h0);
        expect_rsp("R1 miss after reset", 0, 32'h0);
        step(1, 1, 32'h0000_1234, 0, 2'd0, 32'h0);
        expect_rsp("R1 fwh miss after reset", 0, 32'h0);

        // 1 MiB window: host 0xE000_0000 -> local 0x9800_0000
        cur_req = "R10";
        step(0, 0, 32'h0, 1, 2'd2, 32'h9800_E000);
        expect_rd("R10 window readback", 32'h9800_E000);
        step(0, 0, 32'h0, 1, 2'd3, 32'hFFF0_000F);
        expect_rd("R10 mask readback", 32'hFFF0_000F);
        step(0, 0, 32'h0, 1, 2'd1, 32'h0000_0003);   // clear reset-phase flags

        cur_req = "R6";
        step(1, 0, 32'hE001_2345, 0, 2'd1, 32'h0);
        expect_rsp("R6 disabled kind inside window", 0, 32'h0);
        step(0, 0, 32'h0, 0, 2'd1, 32'h0);
        expect_rd("R8 blocked and miss flags set", 32'h0000_0003);
        step(0, 0, 32'h0, 1, 2'd0, 32'h0000_0100);
        expect_rd("R10 ctrl readback", 32'h0000_0100);

        cur_req = "R4";
        step(1, 0, 32'hE001_2345, 0, 2'd0, 32'h0);
        expect_rsp("R4 translate", 1, 32'h9801_2345);
        cur_req = "R11";
        step(1, 0, 32'hE00F_FFFF, 0, 2'd0, 32'h0);
        expect_rsp("R11 last byte inside", 1, 32'h980F_FFFF);
        step(1, 0, 32'hE000_0000, 0, 2'd0, 32'h0);
        expect_rsp("R11 first byte", 1, 32'h9800_0000);
        step(1, 0, 32'hE010_0000, 0, 2'd0, 32'h0);
        expect_rsp("R11 one past end", 0, 32'h0);
        cur_req = "R3";
        step(1, 0, 32'hDFFF_FFFF, 0, 2'd0, 32'h0);
        expect_rsp("R3 below window", 0, 32'h0);
        cur_req = "R5";
        step(1, 0, 32'hE00A_BEEF, 0, 2'd0, 32'h0);
        expect_rsp("R5 low bits pass", 1, 32'h980A_BEEF);
        cur_req = "R6";
        step(1, 1, 32'hE001_2345, 0, 2'd0, 32'h0);
        expect_rsp("R6 fwh disabled", 0, 32'h0);

        // R7 firmware-hub mode
        cur_req = "R7";
        step(0, 0, 32'h0, 1, 2'd0, 32'h0000_0500);
        step(1, 1, 32'hE001_2345, 0, 2'd0, 32'h0);
        expect_rsp("R7 identity when mode clear", 1, 32'hE001_2345);
        step(0, 0, 32'h0, 1, 2'd1, 32'h0002_0000);
        expect_rd("R8 write of 0 keeps flags", 32'h0002_0003);
        step(1, 1, 32'hE001_2345, 0, 2'd1, 32'h0);
        expect_rsp("R7 translated when mode set", 1, 32'h9801_2345);

        // R8 write-one-to-clear
        cur_req = "R8";
        step(0, 0, 32'h0, 1, 2'd1, 32'h0002_0001);
        expect_rd("R8 clear miss flag", 32'h0002_0002);
        step(1, 0, 32'h1000_0000, 1, 2'd1, 32'h0002_0001);
        expect_rd("R8 event beats clear", 32'h0002_0003);
        step(0, 0, 32'h0, 1, 2'd1, 32'h0002_0003);
        expect_rd("R8 clear both", 32'h0002_0000);

        // R9 same-edge write uses old registers
        cur_req = "R9";
        step(1, 0, 32'hE001_2345, 1, 2'd2, 32'h7700_E000);
        expect_rsp("R9 old base on write edge", 1, 32'h9801_2345);
        step(1, 0, 32'hE001_2345, 0, 2'd2, 32'h0);
        expect_rsp("R9 new base afterwards", 1, 32'h7701_2345);

        // R10 unstored bits
        cur_req = "R10";
        step(0, 0, 32'h0, 1, 2'd0, 32'hFFFF_FFFF);
        expect_rd("R10 ctrl stores bits 8 and 10", 32'h0000_0500);
        step(0, 0, 32'h0, 1, 2'd1, 32'hFFFF_FFFF);
        expect_rd("R10 stat stores bit 17", 32'h0002_0000);

        // mixed traffic against the reference
        cur_req = "R3";
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, wd;
            logic [3:0]  pick;
            pick = 4'($urandom);
            a = {m_win[15:0] ^ (16'($urandom) & 16'h0013), 16'($urandom)};
            if (pick == 4'd0) a = $urandom;
            wd = $urandom;
            if (pick == 4'd3) wd = {16'($urandom), 16'hE000};
            step(1'($urandom), 1'($urandom), a, (pick > 4'd12) || (pick == 4'd3),
                 (pick == 4'd3) ? 2'd2 : 2'($urandom), wd);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule